// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block supervises a battery-backed static memory. Every clock it compares a digitized supply reading, an unsigned code in millivolts, against a small set of thresholds. From that comparison it decides three things: whether the memory may be written and driven, whether the backup cell must power the array, and whether the backup cell has been armed. A select input picks one of two tolerance grades, and each grade has its own release and trip levels. A fixed switchover level decides when the array runs from the backup cell.

The block leaves reset in a shipping-seal state. In that state the backup cell stays disconnected, even when the supply is missing. The seal opens the first time the supply rises above the arming level. After that, backup stays armed until the next reset. The sensing, the power switch and the array itself are outside this block; it drives only their control flags.

The supply reading is a plain sampled input with no handshake. A new code is taken on every rising edge, no back-pressure exists, and the outputs are plain level flags. Write cycles are never counted or limited; writes are blocked only because of the supply.

Top module: `pfs_supervisor`

## Requirements
- R1: While reset is asserted, and at its release, sup_state is 0 (sealed), wr_protect=1, io_float=1, batt_sel=0 and batt_armed=0.
- R2: In the sealed state the block stays sealed while the reading is at or below 4250 mV, and batt_sel stays 0 even below 3000 mV.
- R3: A reading above 4250 mV opens the seal. batt_armed then reads 1 and stays 1 until the next reset.
- R4: With hi_tol_sel=1, protection releases (sup_state 1, normal) only for a reading above 4750 mV, and it asserts for a reading at or below 4500 mV.
- R5: With hi_tol_sel=0, protection releases for a reading above 4500 mV and asserts for a reading at or below 4250 mV.
- R6: A reading inside the band between the trip level and the release level leaves the protect state unchanged.
- R7: In every state other than normal, wr_protect=1 and io_float=1. In normal, both are 0.
- R8: Once armed, a reading below 3000 mV selects backup (sup_state 3, batt_sel=1). A reading at or above 3000 mV returns the block to protected (sup_state 2, batt_sel=0), never straight to normal.
- R9: Each output reflects the reading sampled on the previous rising edge, so the latency is one cycle. Leaving backup for normal takes two readings.
- R10: The sup_state encoding is 0 sealed, 1 normal, 2 protected, 3 backup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_mv | input | 13 | Supply reading in millivolts, sampled every edge |
| hi_tol_sel | input | 1 | 1 selects the 4750/4500 mV grade, 0 selects the 4500/4250 mV grade |
| wr_protect | output | 1 | Memory writes blocked |
| io_float | output | 1 | Memory inputs ignored and data outputs high impedance |
| batt_sel | output | 1 | Array powered from the backup cell |
| batt_armed | output | 1 | Shipping seal opened, backup available |
| sup_state | output | 2 | Supervisor state code |

## Verification
Every output is due one rising edge after the reading that causes it. A move from backup to normal needs one edge to reach protected and a second edge to reach normal. The driver applies each reading at a falling edge and queues the expected outputs for that reading. The monitor compares those outputs 2 ns after the next rising edge, so each comparison lands exactly one register stage after its stimulus. The double-step recovery is therefore checked as two queued items.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_SEALED  = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_PROTECT = 2'd2,
    ST_BACKUP  = 2'd3
  } pfs_state_e;

  typedef struct packed {
    logic above_full;
    logic at_trip;
    logic below_sw;
    logic above_seal;
  } pfs_flags_t;
endpackage

// File: rtl/pfs_threshold.sv
module pfs_threshold
  import pfs_pkg::*;
#(
  parameter int VW         = 13,
  parameter int HI_FULL_MV = 4750,
  parameter int HI_TRIP_MV = 4500,
  parameter int LO_FULL_MV = 4500,
  parameter int LO_TRIP_MV = 4250,
  parameter int SEAL_MV    = 4250,
  parameter int SWITCH_MV  = 3000
) (
  input  logic [VW-1:0] vcc_mv,
  input  logic          hi_tol_sel,
  output pfs_flags_t    flags
);
  localparam logic [VW-1:0] HI_FULL = VW'(HI_FULL_MV);
  localparam logic [VW-1:0] HI_TRIP = VW'(HI_TRIP_MV);
  localparam logic [VW-1:0] LO_FULL = VW'(LO_FULL_MV);
  localparam logic [VW-1:0] LO_TRIP = VW'(LO_TRIP_MV);
  localparam logic [VW-1:0] SEAL    = VW'(SEAL_MV);
  localparam logic [VW-1:0] SWITCH  = VW'(SWITCH_MV);

  logic [VW-1:0] full_lvl;
  logic [VW-1:0] trip_lvl;

  assign full_lvl = hi_tol_sel ? HI_FULL : LO_FULL;
  assign trip_lvl = hi_tol_sel ? HI_TRIP : LO_TRIP;

  always_comb begin
    flags.above_full = (vcc_mv > full_lvl);
    flags.at_trip    = (vcc_mv <= trip_lvl);
    flags.below_sw   = (vcc_mv < SWITCH);
    flags.above_seal = (vcc_mv > SEAL);
  end
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfs_flags_t flags,
  output pfs_state_e state
);
  pfs_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_SEALED: begin
        if (flags.above_seal)
          nxt = flags.above_full ? ST_NORMAL : ST_PROTECT;
      end
      ST_NORMAL: begin
        if (flags.below_sw)     nxt = ST_BACKUP;
        else if (flags.at_trip) nxt = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (flags.below_sw)        nxt = ST_BACKUP;
        else if (flags.above_full) nxt = ST_NORMAL;
      end
      ST_BACKUP: begin
        if (!flags.below_sw) nxt = ST_PROTECT;
      end
      default: nxt = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SEALED;
    else        state <= nxt;
  end

  AST_NO_RESEAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SEALED) |=> (state != ST_SEALED)) else $error("reseal"); // R3
  AST_BACKUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKUP) |=> (state != ST_NORMAL)) else $error("skip"); // R8
endmodule

// File: rtl/pfs_outdec.sv
module pfs_outdec
  import pfs_pkg::*;
(
  input  pfs_state_e state,
  output logic       wr_protect,
  output logic       io_float,
  output logic       batt_sel,
  output logic       batt_armed
);
  always_comb begin
    wr_protect = (state != ST_NORMAL);
    io_float   = (state != ST_NORMAL);
    batt_sel   = (state == ST_BACKUP);
    batt_armed = (state != ST_SEALED);
  end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int VW         = 13,
  parameter int HI_FULL_MV = 4750,
  parameter int HI_TRIP_MV = 4500,
  parameter int LO_FULL_MV = 4500,
  parameter int LO_TRIP_MV = 4250,
  parameter int SEAL_MV    = 4250,
  parameter int SWITCH_MV  = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vcc_mv,
  input  logic          hi_tol_sel,
  output logic          wr_protect,
  output logic          io_float,
  output logic          batt_sel,
  output logic          batt_armed,
  output logic [1:0]    sup_state
);
  pfs_flags_t flags;
  pfs_state_e state;

  pfs_threshold #(
    .VW(VW), .HI_FULL_MV(HI_FULL_MV), .HI_TRIP_MV(HI_TRIP_MV),
    .LO_FULL_MV(LO_FULL_MV), .LO_TRIP_MV(LO_TRIP_MV),
    .SEAL_MV(SEAL_MV), .SWITCH_MV(SWITCH_MV)
  ) u_thr (
    .vcc_mv(vcc_mv), .hi_tol_sel(hi_tol_sel), .flags(flags)
  );

  pfs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flags(flags), .state(state)
  );

  pfs_outdec u_dec (
    .state(state), .wr_protect(wr_protect), .io_float(io_float),
    .batt_sel(batt_sel), .batt_armed(batt_armed)
  );

  assign sup_state = state;

  AST_TRIP_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    flags.at_trip |=> wr_protect) else $error("trip"); // R4
  AST_RESUME_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_protect) |-> $past(flags.above_full)) else $error("resume"); // R5
  AST_SEALED_NO_BATT: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_armed |-> !batt_sel) else $error("seal batt"); // R2
  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    batt_armed |=> batt_armed) else $error("armed"); // R3
  AST_BACKUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.below_sw && batt_armed) |=> batt_sel) else $error("backup"); // R8
  AST_FLOAT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_state != 2'd1) |-> (wr_protect && io_float)) else $error("float"); // R7
endmodule

// File: tb/pfs_supervisor_bench.sv
module pfs_supervisor_bench;
  typedef struct {
    logic [5:0] exp;
    string      tag;
    int         mv;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] vcc_mv = '0;
  logic        hi_tol_sel = 1'b1;
  logic        wr_protect, io_float, batt_sel, batt_armed;
  logic [1:0]  sup_state;

  int checks = 0;
  int errors = 0;
  item_t q[$];

  always #4 clk = ~clk;

  pfs_supervisor u_pfs_supervisor (
    .clk(clk), .rst_n(rst_n), .vcc_mv(vcc_mv), .hi_tol_sel(hi_tol_sel),
    .wr_protect(wr_protect), .io_float(io_float), .batt_sel(batt_sel),
    .batt_armed(batt_armed), .sup_state(sup_state)
  );

  // expected {state, wp, float, bsel, armed} from R7, R8, R10
  function automatic logic [5:0] exp_of(int st);
    case (st)
      0:       return {2'd0, 4'b1100};
      1:       return {2'd1, 4'b0001};
      2:       return {2'd2, 4'b1101};
      default: return {2'd3, 4'b1111};
    endcase
  endfunction

  function automatic logic [5:0] act();
    return {sup_state, wr_protect, io_float, batt_sel, batt_armed};
  endfunction

  task automatic step(int mv, int st, string tag);
    item_t it;
    @(negedge clk);
    vcc_mv = 13'(mv);
    it.exp = exp_of(st);
    it.tag = tag;
    it.mv  = mv;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    vcc_mv = 13'd0;
    repeat (2) @(negedge clk);
    checks++;
    if (act() !== exp_of(0)) begin
      errors++;
      $display("FAIL R1 reset act=%b exp=%b", act(), exp_of(0));
    end
    rst_n = 1'b1;
  endtask

  // monitor: one edge after each stimulus (R9)
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (act() !== it.exp) begin
        errors++;
        $display("FAIL %s mv=%0d act=%b exp=%b", it.tag, it.mv, act(), it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=%b exp=done", act());
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    hi_tol_sel = 1'b1;
    step(0,    0, "R2 sealed no batt");
    step(2000, 0, "R2 sealed low");
    step(4200, 0, "R2 sealed below arm");
    step(4251, 2, "R3 seal opens");
    step(4600, 2, "R6 band hi");
    step(4751, 1, "R4 release hi");
    step(4600, 1, "R6 band keeps normal");
    step(4500, 2, "R4 trip hi");
    step(4700, 2, "R6 band keeps protect");
    step(4800, 1, "R4 release again");
    step(3500, 2, "R7 protected");
    step(2999, 3, "R8 backup");
    step(1000, 3, "R8 backup hold");
    step(3000, 2, "R8 leave backup");
    step(4751, 1, "R9 second step");
    hi_tol_sel = 1'b0;
    step(4400, 1, "R5 lo above trip");
    step(4250, 2, "R5 trip lo");
    step(4400, 2, "R6 band lo");
    step(4501, 1, "R5 release lo");
    step(2000, 3, "R8 backup lo");
    step(0,    3, "R3 armed at zero");
    step(5000, 2, "R9 backup to protect");
    step(5000, 1, "R9 protect to normal");
    repeat (3) @(negedge clk);
    do_reset();
    step(2000, 0, "R2 resealed");
    step(4250, 0, "R2 at arm level");
    step(4300, 2, "R3 arm below lo full");
    step(4501, 1, "R10 normal code");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule